// File: doc/BRIEF.md
# Soft-Decision Depuncturer for Dual Mother Codes

This block takes signed soft decisions from a satellite demodulator and rebuilds the full-rate branch stream that a convolutional decoder expects. Each input symbol carries one soft decision in BPSK form or an I/Q pair in QPSK and offset-QPSK form. The block first realigns the offset-QPSK quadrature lane and applies a selectable phase rotation and lane swap. It then walks a puncture pattern and emits one branch tuple per information bit, filling each deleted code bit with a zero erasure and flagging it.

Two mother codes share the datapath. A rate-1/2 code produces pairs on lanes A and B. A rate-1/3 code produces triples on lanes A, B and C. Inserting erasures makes the output tuple rate higher than the rate of incoming code bits, so a small reorder buffer sits between the two sides and an input-ready signal throttles the source. A node-sync controller outside the block drives the rotation, swap, rate and pattern-phase inputs while it searches for lock. The decoder core and the search logic are outside this block.

Top module: `depuncturer`

## Requirements
- R1: While reset is asserted and in the cycle after it, `out_valid` is 0 and `in_ready` is 1, the buffer is empty and the pattern step is 0.
- R2: With `cfg_family`=0 (rate-1/2 code), `cfg_rate` selects the rate as 0:1/2, 1:2/3, 2:3/4, 3:5/6, 4:6/7, 5:7/8, and 6 or 7 select 1/2. The kept masks per step for lanes A/B are: 1/2 A=1 B=1; 2/3 A=10 B=11; 3/4 A=101 B=110; 5/6 A=10101 B=11010; 6/7 A=100101 B=111010; 7/8 A=1000101 B=1111010. Lane C is always erased.
- R3: An erased lane carries the value 0 and has its bit set in `out_erase` (bit0=A, bit1=B, bit2=C). A kept lane has its bit clear.
- R4: With `cfg_family`=1 (rate-1/3 code), the rate codes are 0:5/11, 1:1/2, 2:3/5, 3:2/3, 4:3/4, 5:4/5, 6:5/6, 7:7/8, with periods 5,1,3,2,3,4,5,7. Step 0 keeps A,B,C for 5/11 and keeps A,B for the other rates. In later steps, 5/11 keeps A,B. For 3/5, step 1 keeps A,B and step 2 keeps A. For the other rates every later step keeps A only, and 1/2 keeps A,B.
- R5: Code bits are used in arrival order. A symbol contributes lane 0 and then lane 1. Within a tuple, kept lanes are filled in the order A, B, C.
- R6: With `cfg_mod`=0 (BPSK), each symbol contributes one code bit, `in_i`, negated when `cfg_rot[1]`=1. `in_q`, `cfg_swap` and `cfg_rot[0]` are ignored.
- R7: With `cfg_mod`=2 (offset QPSK), `in_i` of one accepted symbol is paired with `in_q` of the next accepted symbol. The first accepted symbol after reset contributes no code bits. Modes 1 and 3 pair I and Q of the same symbol.
- R8: In the pair modes, `cfg_rot` maps the pair (a,b) to 0:(a,b), 1:(b,-a), 2:(-a,-b), 3:(-b,a). Negation saturates, so the most negative value becomes the most positive value.
- R9: `cfg_swap`=1 exchanges a and b before the rotation is applied.
- R10: The pattern index used for a tuple is (k + `cfg_phase`) mod period, where k counts the tuples emitted since reset, taken mod period.
- R11: `in_ready` is 1 exactly when at most DEPTH-2 code bits are buffered, and the buffer never holds more than DEPTH. A tuple is emitted in every cycle in which the buffered bits plus the bits accepted in that cycle cover the current step's kept lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_family | input | 1 | 0: rate-1/2 mother code, 1: rate-1/3 mother code |
| cfg_rate | input | 3 | Puncture rate code |
| cfg_mod | input | 2 | 0 BPSK, 1 QPSK, 2 offset QPSK, 3 as QPSK |
| cfg_rot | input | 2 | Phase rotation in quarter turns |
| cfg_swap | input | 1 | Exchange I and Q before rotation |
| cfg_phase | input | 3 | Start offset within the puncture period |
| in_valid | input | 1 | Input symbol present |
| in_i | input | SW | In-phase soft decision, two's complement |
| in_q | input | SW | Quadrature soft decision, two's complement |
| in_ready | output | 1 | Symbol is accepted when both valid and ready are 1 |
| out_valid | output | 1 | Branch tuple strobe |
| out_a | output | SW | Lane A soft value |
| out_b | output | SW | Lane B soft value |
| out_c | output | SW | Lane C soft value |
| out_erase | output | 3 | Per-lane erasure flags {C,B,A} |

## Verification
A wrong buffer count or a wrong read pointer shows up as a shifted soft value on a kept lane in the very next tuple, and it stays visible because every later tuple inherits the slip. A wrong step counter or phase sum moves an erasure flag to a different lane within one puncture period, at most seven tuples. A lost or duplicated code bit breaks the exact relation between `in_ready` and the number of bits still pending, and that relation is checked in every cycle. Saturating negation and offset-QPSK pairing are each checked on the first tuple that uses them.

// File: rtl/depunc_pkg.sv
package depunc_pkg;

    // Puncture period for a family/rate code.
    function automatic logic [2:0] pat_len(input logic fam, input logic [2:0] rate);
        logic [2:0] len;
        if (!fam) begin
            case (rate)
                3'd1:    len = 3'd2;
                3'd2:    len = 3'd3;
                3'd3:    len = 3'd5;
                3'd4:    len = 3'd6;
                3'd5:    len = 3'd7;
                default: len = 3'd1;
            endcase
        end else begin
            case (rate)
                3'd0:    len = 3'd5;
                3'd1:    len = 3'd1;
                3'd2:    len = 3'd3;
                3'd3:    len = 3'd2;
                3'd4:    len = 3'd3;
                3'd5:    len = 3'd4;
                3'd6:    len = 3'd5;
                default: len = 3'd7;
            endcase
        end
        return len;
    endfunction

    // Kept-lane mask {C,B,A} for one pattern step.
    function automatic logic [2:0] pat_mask(input logic fam, input logic [2:0] rate,
                                            input logic [2:0] idx);
        logic [6:0] xa, yb;
        logic [2:0] m;
        if (!fam) begin
            case (rate)
                3'd1:    begin xa = 7'b1000000; yb = 7'b1100000; end
                3'd2:    begin xa = 7'b1010000; yb = 7'b1100000; end
                3'd3:    begin xa = 7'b1010100; yb = 7'b1101000; end
                3'd4:    begin xa = 7'b1001010; yb = 7'b1110100; end
                3'd5:    begin xa = 7'b1000101; yb = 7'b1111010; end
                default: begin xa = 7'b1000000; yb = 7'b1000000; end
            endcase
            m = {1'b0, xa[3'd6 - idx], yb[3'd6 - idx]};
            m = {1'b0, m[0], m[1]};
        end else begin
            if (rate == 3'd0)
                m = (idx == 3'd0) ? 3'b111 : 3'b011;
            else if (rate == 3'd1 || idx == 3'd0)
                m = 3'b011;
            else if (rate == 3'd2 && idx == 3'd1)
                m = 3'b011;
            else
                m = 3'b001;
        end
        return m;
    endfunction

endpackage

// File: rtl/depunc_front.sv
module depunc_front #(
    parameter int SW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic [1:0]    rot,
    input  logic          swap,
    input  logic          accept,
    input  logic [SW-1:0] in_i,
    input  logic [SW-1:0] in_q,
    output logic [1:0]    push_n,
    output logic [SW-1:0] push0,
    output logic [SW-1:0] push1
);
    localparam logic [SW-1:0] SMIN = {1'b1, {(SW-1){1'b0}}};
    localparam logic [SW-1:0] SMAX = ~SMIN;

    typedef struct packed {
        logic [SW-1:0] held_i;
        logic          held_vld;
    } fr_t;

    fr_t fr_d, fr_q;

    function automatic logic [SW-1:0] sneg(input logic [SW-1:0] x);
        return (x == SMIN) ? SMAX : (~x + 1'b1);
    endfunction

    logic [SW-1:0] a_raw, b_raw, a_sw, b_sw;
    logic [1:0]    n_raw;

    always_comb begin
        fr_d  = fr_q;
        a_raw = in_i;
        b_raw = in_q;
        n_raw = 2'd2;
        if (mode == 2'd2) begin
            a_raw = fr_q.held_i;
            if (!fr_q.held_vld) n_raw = 2'd0;
            if (accept) begin
                fr_d.held_i   = in_i;
                fr_d.held_vld = 1'b1;
            end
        end else begin
            fr_d.held_vld = 1'b0;
        end
        a_sw = swap ? b_raw : a_raw;
        b_sw = swap ? a_raw : b_raw;
        case (rot)
            2'd1:    begin push0 = b_sw;       push1 = sneg(a_sw); end
            2'd2:    begin push0 = sneg(a_sw); push1 = sneg(b_sw); end
            2'd3:    begin push0 = sneg(b_sw); push1 = a_sw;       end
            default: begin push0 = a_sw;       push1 = b_sw;       end
        endcase
        if (mode == 2'd0) begin
            n_raw = 2'd1;
            push0 = rot[1] ? sneg(in_i) : in_i;
            push1 = '0;
        end
        push_n = accept ? n_raw : 2'd0;
    end

    always_ff @(posedge clk) begin
        if (rst) fr_q <= '0;
        else     fr_q <= fr_d;
    end

endmodule

// File: rtl/depunc_core.sv
module depunc_core
    import depunc_pkg::*;
#(
    parameter int SW    = 6,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fam,
    input  logic [2:0]    rate,
    input  logic [2:0]    phase,
    input  logic [1:0]    push_n,
    input  logic [SW-1:0] push0,
    input  logic [SW-1:0] push1,
    output logic          in_ready,
    output logic          out_valid,
    output logic [SW-1:0] out_a,
    output logic [SW-1:0] out_b,
    output logic [SW-1:0] out_c,
    output logic [2:0]    out_erase
);
    localparam int CATN = DEPTH + 3;
    localparam int CW   = $clog2(CATN);

    typedef struct packed {
        logic [DEPTH-1:0][SW-1:0] buf_v;
        logic [CW-1:0]            count;
        logic [2:0]               step;
        logic                     ov;
        logic [2:0][SW-1:0]       lane;
        logic [2:0]               era;
    } cs_t;

    cs_t st_d, st_q;

    logic [2:0]    len, step_eff, idx, mask;
    logic [CW-1:0] need, total, pop;
    logic          emit;
    logic [SW-1:0] cat [CATN];
    int            ptr;

    always_comb begin
        st_d     = st_q;
        len      = pat_len(fam, rate);
        step_eff = (st_q.step < len) ? st_q.step : 3'd0;
        idx      = 3'(({1'b0, step_eff} + {1'b0, phase}) % {1'b0, len});
        mask     = pat_mask(fam, rate, idx);
        need     = CW'($countones(mask));
        total    = st_q.count + CW'(push_n);
        for (int j = 0; j < CATN; j++) begin
            if (CW'(j) < st_q.count)           cat[j] = st_q.buf_v[j % DEPTH];
            else if (CW'(j) == st_q.count)     cat[j] = push0;
            else if (CW'(j) == st_q.count + 1) cat[j] = push1;
            else                               cat[j] = '0;
        end
        emit = (total >= need);
        pop  = emit ? need : '0;
        ptr  = 0;
        for (int k = 0; k < 3; k++) begin
            if (mask[k]) begin
                st_d.lane[k] = emit ? cat[ptr] : '0;
                ptr          = ptr + 1;
            end else begin
                st_d.lane[k] = '0;
            end
        end
        for (int j = 0; j < DEPTH; j++)
            st_d.buf_v[j] = cat[j + int'(pop)];
        st_d.count = total - pop;
        st_d.ov    = emit;
        st_d.era   = emit ? ~mask : 3'b000;
        if (emit) st_d.step = (step_eff + 3'd1 == len) ? 3'd0 : step_eff + 3'd1;
        else      st_d.step = step_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign in_ready  = (st_q.count <= CW'(DEPTH - 2));
    assign out_valid = st_q.ov;
    assign out_a     = st_q.lane[0];
    assign out_b     = st_q.lane[1];
    assign out_c     = st_q.lane[2];
    assign out_erase = st_q.era;

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        st_q.count <= CW'(DEPTH));

    assert_erase_zero_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((!out_erase[0] || out_a == '0) && (!out_erase[1] || out_b == '0)
                       && (!out_erase[2] || out_c == '0)));

    assert_half_lane_c_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(fam)) |-> out_erase[2]);

    assert_step_range_R10: assert property (@(posedge clk) disable iff (rst)
        ($stable(fam) && $stable(rate)) |-> (st_q.step < len));

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

endmodule

// File: rtl/depuncturer.sv
module depuncturer #(
    parameter int SW    = 6,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_family,
    input  logic [2:0]    cfg_rate,
    input  logic [1:0]    cfg_mod,
    input  logic [1:0]    cfg_rot,
    input  logic          cfg_swap,
    input  logic [2:0]    cfg_phase,
    input  logic          in_valid,
    input  logic [SW-1:0] in_i,
    input  logic [SW-1:0] in_q,
    output logic          in_ready,
    output logic          out_valid,
    output logic [SW-1:0] out_a,
    output logic [SW-1:0] out_b,
    output logic [SW-1:0] out_c,
    output logic [2:0]    out_erase
);
    logic [1:0]    push_n;
    logic [SW-1:0] push0, push1;
    logic          accept;

    assign accept = in_valid && in_ready;

    depunc_front #(.SW(SW)) u_front (
        .clk(clk), .rst(rst), .mode(cfg_mod), .rot(cfg_rot), .swap(cfg_swap),
        .accept(accept), .in_i(in_i), .in_q(in_q),
        .push_n(push_n), .push0(push0), .push1(push1)
    );

    depunc_core #(.SW(SW), .DEPTH(DEPTH)) u_core (
        .clk(clk), .rst(rst), .fam(cfg_family), .rate(cfg_rate), .phase(cfg_phase),
        .push_n(push_n), .push0(push0), .push1(push1),
        .in_ready(in_ready), .out_valid(out_valid),
        .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_erase(out_erase)
    );

endmodule

// File: tb/depuncturer_tb.sv
`timescale 1ns/1ps
module depuncturer_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_family = 1'b0;
    logic [2:0] cfg_rate = '0, cfg_phase = '0;
    logic [1:0] cfg_mod = '0, cfg_rot = '0;
    logic cfg_swap = 1'b0;
    logic in_valid = 1'b0;
    logic [5:0] in_i = '0, in_q = '0;
    logic in_ready, out_valid;
    logic [5:0] out_a, out_b, out_c;
    logic [2:0] out_erase;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    logic [5:0] mq [0:8191];
    int hd, tl, step;
    logic [5:0] held;
    bit held_v;

    always #2.5 clk = ~clk;

    depuncturer u_dut (
        .clk(clk), .rst(rst), .cfg_family(cfg_family), .cfg_rate(cfg_rate),
        .cfg_mod(cfg_mod), .cfg_rot(cfg_rot), .cfg_swap(cfg_swap), .cfg_phase(cfg_phase),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q), .in_ready(in_ready),
        .out_valid(out_valid), .out_a(out_a), .out_b(out_b), .out_c(out_c),
        .out_erase(out_erase)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [5:0] bneg(input logic [5:0] x);
        return (x == 6'h20) ? 6'h1F : (~x + 6'd1);
    endfunction

    function automatic int b_len(input bit f, input logic [2:0] r);
        if (!f) begin
            case (r)
                1: return 2; 2: return 3; 3: return 5; 4: return 6; 5: return 7;
                default: return 1;
            endcase
        end
        case (r)
            0: return 5; 1: return 1; 2: return 3; 3: return 2;
            4: return 3; 5: return 4; 6: return 5; default: return 7;
        endcase
    endfunction

    // Masks from R2 / R4, stored first-step-in-bit-0.
    function automatic logic [2:0] b_mask(input bit f, input logic [2:0] r, input int i);
        logic [6:0] x, y;
        int kept;
        if (!f) begin
            case (r)
                1: begin x = 7'b0000001; y = 7'b0000011; end
                2: begin x = 7'b0000101; y = 7'b0000011; end
                3: begin x = 7'b0010101; y = 7'b0001011; end
                4: begin x = 7'b0101001; y = 7'b0010111; end
                5: begin x = 7'b1010001; y = 7'b0101111; end
                default: begin x = 7'b0000001; y = 7'b0000001; end
            endcase
            return {1'b0, y[i], x[i]};
        end
        if (r == 0)                kept = (i == 0) ? 3 : 2;
        else if (r == 1 || i == 0) kept = 2;
        else if (r == 2 && i == 1) kept = 2;
        else                       kept = 1;
        return (kept == 3) ? 3'b111 : (kept == 2) ? 3'b011 : 3'b001;
    endfunction

    task automatic mpush(input logic [5:0] v);
        mq[tl % 8192] = v;
        tl++;
    endtask

    task automatic model_accept(input logic [5:0] i, input logic [5:0] q);
        logic [5:0] a, b, t;
        if (cfg_mod == 2'd0) begin
            mpush(cfg_rot[1] ? bneg(i) : i);   // R6
            return;
        end
        a = i; b = q;
        if (cfg_mod == 2'd2) begin            // R7
            if (!held_v) begin
                held = i; held_v = 1'b1;
                return;
            end
            a = held; held = i;
        end
        if (cfg_swap) begin t = a; a = b; b = t; end   // R9
        case (cfg_rot)                                  // R8
            2'd1: begin t = a; a = b; b = bneg(t); end
            2'd2: begin a = bneg(a); b = bneg(b); end
            2'd3: begin t = a; a = bneg(b); b = t; end
            default: ;
        endcase
        mpush(a);
        mpush(b);
    endtask

    task automatic observe(input string tag);
        int len, idx, need, pend;
        logic [2:0] m;
        logic [17:0] ev;
        logic [2:0] ee;
        len  = b_len(cfg_family, cfg_rate);
        idx  = (step + int'(cfg_phase)) % len;          // R10
        m    = b_mask(cfg_family, cfg_rate, idx);
        need = $countones(m);
        pend = tl - hd;
        if (out_valid) begin
            if (pend < need) begin
                chk(1'b0, "R11", "tuple emitted without enough bits", pend, need);
            end else begin
                ev = '0;
                for (int k = 0; k < 3; k++)
                    if (m[k]) begin
                        ev[k*6 +: 6] = mq[hd % 8192];
                        hd++;
                    end
                ee = ~m;
                chk({out_c, out_b, out_a} == ev && out_erase == ee, tag,
                    "tuple lanes/erasures (R5, R3 erasure=0)",
                    {11'd0, out_erase, out_c, out_b, out_a}, {11'd0, ee, ev});
            end
            step = (step + 1) % len;
        end else begin
            chk(pend < need, "R11", "tuple withheld with enough bits", pend, need);
        end
        pend = tl - hd;
        chk(in_ready == (pend <= 2), "R11", "in_ready vs pending bits", in_ready, pend <= 2);
    endtask

    task automatic run_seg(input bit f, input logic [2:0] r, input logic [1:0] md,
                           input logic [1:0] rt, input bit sw, input logic [2:0] ph,
                           input int cycles, input int vprob, input bit force_min,
                           input string tag);
        bit v;
        cfg_family = f; cfg_rate = r; cfg_mod = md; cfg_rot = rt;
        cfg_swap = sw; cfg_phase = ph;
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", "reset state",
            {out_valid, in_ready}, 2'b01);
        rst = 1'b0;
        hd = 0; tl = 0; step = 0; held_v = 1'b0; held = '0;
        for (int c = 0; c < cycles + 12; c++) begin
            @(negedge clk);
            observe(tag);
            v = (c < cycles) && (($urandom % 100) < vprob);
            in_valid = v;
            in_i = force_min ? 6'h20 : 6'($urandom);
            in_q = force_min ? 6'h20 : 6'($urandom);
            if (v && in_ready) model_accept(in_i, in_q);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        bit f;
        logic [2:0] r;
        void'($urandom(32'd20240611));
        run_seg(0, 3'd2, 2'd1, 2'd0, 0, 3'd0, 300, 80, 0, "R2");   // 3/4 rate-1/2 code
        run_seg(0, 3'd5, 2'd1, 2'd0, 0, 3'd3, 300, 70, 0, "R10");  // 7/8 with phase
        run_seg(0, 3'd4, 2'd0, 2'd2, 1, 3'd1, 300, 90, 0, "R6");   // BPSK, swap ignored
        run_seg(1, 3'd0, 2'd1, 2'd0, 0, 3'd2, 300, 80, 0, "R4");   // 5/11 rate-1/3 code
        run_seg(1, 3'd2, 2'd2, 2'd0, 0, 3'd0, 300, 80, 0, "R7");   // offset QPSK
        run_seg(0, 3'd0, 2'd1, 2'd1, 1, 3'd0, 300, 60, 0, "R9");   // swap + rot 1
        run_seg(1, 3'd7, 2'd1, 2'd3, 0, 3'd6, 300, 80, 0, "R8");   // rot 3, phase 6
        run_seg(0, 3'd3, 2'd1, 2'd2, 0, 3'd2, 60, 100, 1, "R8");   // saturating negation
        run_seg(0, 3'd1, 2'd1, 2'd0, 0, 3'd1, 300, 100, 0, "R11"); // full-rate source
        for (int s = 0; s < 8; s++) begin
            f = 1'($urandom);
            r = f ? 3'($urandom % 8) : 3'($urandom % 6);
            run_seg(f, r, 2'($urandom % 3), 2'($urandom), 1'($urandom),
                    3'($urandom % b_len(f, r)), 300, 40 + ($urandom % 61), 0, "R5");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL R11 watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule